// File: doc/BRIEF.md
# Locked Page-Write Load Controller

This block is the device-side write logic of a byte-wide nonvolatile memory model. It watches a synchronous write strobe carrying a 17-bit address and an 8-bit data byte. Writes stay locked at all times. A page write opens only after a fixed three-write unlock sequence. The block then gathers between 1 and 128 bytes of one page into an internal page buffer. Loading closes once the gap between accepted bytes grows too long. A fixed programming period follows. The loaded bytes are then handed, one per cycle in ascending offset order, to a simple storage array through a commit port. When that scan completes, the block is locked again.

A write that breaks the unlock sequence still costs a full programming period, but nothing is committed. After reset, a power-on delay counted in clock cycles keeps every write out. While programming or committing, the block raises `busy` and ignores the write strobe. The power-on delay, the byte gap limit and the programming time are all parameters in clock cycles.

Top module: `locked_page_loader`

## Requirements
- R1: From reset release, `busy` is 1 and every write is ignored for PON_CYC cycles. After that, `busy` is 0.
- R2: Loading opens only after three consecutive writes: data 8'hAA at address 15'h5555, then 8'h55 at 15'h2AAA, then 8'hA0 at 15'h5555. Only address bits 14..0 are compared, so bits 16..15 are don't-care.
- R3: The data of the three unlock writes is never presented on the commit port.
- R4: Any write that does not match the expected unlock step returns the sequence to its first step. It also starts a full programming period (busy) in which no commit pulse occurs.
- R5: A load takes its byte offset from address bits 6..0 and its page from bits 16..7. The first accepted byte latches the page. A later load with a different page is discarded and does not restart the gap timer.
- R6: Bytes may be loaded in any order. A reloaded offset keeps its last value. Only offsets loaded in this page write are committed, and they are committed in ascending offset order.
- R7: Loading ends when BLC_CYC cycles pass without an accepted byte. A byte that arrives exactly BLC_CYC cycles after the previous accepted byte is still accepted. Once loading ends, `busy` is 1 from the next cycle on.
- R8: After `busy` rises, the block spends WC_CYC cycles programming and then scans the 128 offsets, one per cycle. Offset i appears on `cm_en`/`cm_addr`/`cm_data` in cycle WC_CYC+i after the rise, if it was loaded. The block then drops `busy` and is locked again.
- R9: Writes that arrive while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 17 | Write address: page in bits 16..7, offset in bits 6..0 |
| wr_data | input | 8 | Write data |
| busy | output | 1 | Power-up, programming or commit scan in progress |
| cm_en | output | 1 | Commit one byte to the storage array |
| cm_addr | output | 17 | Array address of the committed byte |
| cm_data | output | 8 | Committed byte value |

## Verification
Results fall due at fixed delays. A write sampled at one edge moves the unlock step or the page buffer at that same edge. Loading closes BLC_CYC edges after the last accepted byte, and `busy` is high in the cycle that follows. Offset i of the page is committed WC_CYC+i cycles after `busy` rises. `busy` drops PON_CYC cycles after reset, and 128 cycles after the scan starts. A behavioural reference model in the bench advances at each rising edge from the same sampled inputs. The outputs are compared against it at every falling edge, so each result is checked in the exact cycle it is due. A shadow array filled from the commit port then backs the named, per-requirement content checks.

// File: rtl/lpl_pkg.sv
package lpl_pkg;

    localparam int UNL_AW = 15;

    typedef enum logic [2:0] {
        PH_PWR  = 3'd0,
        PH_IDLE = 3'd1,
        PH_LOAD = 3'd2,
        PH_PROG = 3'd3,
        PH_SCAN = 3'd4
    } lpl_phase_e;

    function automatic logic [UNL_AW-1:0] unl_addr(input logic [1:0] step);
        return (step == 2'd1) ? 15'h2AAA : 15'h5555;
    endfunction

    function automatic logic [7:0] unl_data(input logic [1:0] step);
        case (step)
            2'd0:    return 8'hAA;
            2'd1:    return 8'h55;
            default: return 8'hA0;
        endcase
    endfunction

endpackage

// File: rtl/lpl_unlock.sv
module lpl_unlock
    import lpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe,
    input  logic [UNL_AW-1:0] addr,
    input  logic [7:0]        data,
    output logic              done,
    output logic              miss
);
    logic [1:0] step_q, step_d;
    logic       hit;

    always_comb begin
        hit    = probe && (addr == unl_addr(step_q)) && (data == unl_data(step_q));
        done   = hit && (step_q == 2'd2);
        miss   = probe && !hit;
        step_d = step_q;
        if (miss || done) begin
            step_d = 2'd0;
        end else if (hit) begin
            step_d = step_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 2'd0;
        end else begin
            step_q <= step_d;
        end
    end

    // R4
    step_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (step_q == 2'd0));

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_q != 2'd3);

endmodule

// File: rtl/lpl_pagebuf.sv
module lpl_pagebuf #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [OFF_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic              rvld
);
    logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q, vld_d;

    always_comb begin
        vld_d = vld_q;
        if (clr) begin
            vld_d = '0;
        end else if (we) begin
            vld_d[widx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
    assign rvld  = vld_q[ridx];

    // R6
    last_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (vld_q[$past(widx)] && mem_q[$past(widx)] == $past(wdata)));

    // R3
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));

endmodule

// File: rtl/locked_page_loader.sv
module locked_page_loader
    import lpl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128,
    parameter int PON_CYC    = 50,
    parameter int BLC_CYC    = 20,
    parameter int WC_CYC     = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [16:0]       wr_addr,
    input  logic [7:0]        wr_data,
    output logic              busy,
    output logic              cm_en,
    output logic [16:0]       cm_addr,
    output logic [7:0]        cm_data
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int MAX_A = (PON_CYC > BLC_CYC) ? PON_CYC : BLC_CYC;
    localparam int MAX_B = (WC_CYC > PAGE_BYTES) ? WC_CYC : PAGE_BYTES;
    localparam int CMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(CMAX + 1);

    typedef struct packed {
        lpl_phase_e       ph;
        logic [CNT_W-1:0] cnt;
        logic             have;
        logic [PG_W-1:0]  pg;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             unl_probe, unl_done, unl_miss;
    logic             buf_we, buf_clr;
    logic [DATA_W-1:0] buf_rdata;
    logic             buf_rvld;
    logic [PG_W-1:0]  in_pg;

    assign in_pg     = wr_addr[ADDR_W-1:OFF_W];
    assign unl_probe = (ctl_q.ph == PH_IDLE) && wr_en;

    lpl_unlock u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .probe (unl_probe),
        .addr  (wr_addr[UNL_AW-1:0]),
        .data  (wr_data),
        .done  (unl_done),
        .miss  (unl_miss)
    );

    lpl_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (buf_we),
        .widx  (wr_addr[OFF_W-1:0]),
        .wdata (wr_data),
        .ridx  (ctl_q.cnt[OFF_W-1:0]),
        .rdata (buf_rdata),
        .rvld  (buf_rvld)
    );

    always_comb begin
        ctl_d   = ctl_q;
        buf_we  = 1'b0;
        buf_clr = 1'b0;
        case (ctl_q.ph)
            PH_PWR: begin
                if (ctl_q.cnt == CNT_W'(PON_CYC - 1)) begin
                    ctl_d.ph  = PH_IDLE;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            PH_IDLE: begin
                if (unl_done) begin
                    ctl_d.ph   = PH_LOAD;
                    ctl_d.cnt  = '0;
                    ctl_d.have = 1'b0;
                    buf_clr    = 1'b1;
                end else if (unl_miss) begin
                    ctl_d.ph  = PH_PROG;
                    ctl_d.cnt = '0;
                    buf_clr   = 1'b1;
                end
            end
            PH_LOAD: begin
                if (wr_en && (!ctl_q.have || in_pg == ctl_q.pg)) begin
                    buf_we     = 1'b1;
                    ctl_d.have = 1'b1;
                    ctl_d.pg   = in_pg;
                    ctl_d.cnt  = '0;
                end else if (ctl_q.cnt == CNT_W'(BLC_CYC - 1)) begin
                    ctl_d.ph  = PH_PROG;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            PH_PROG: begin
                if (ctl_q.cnt == CNT_W'(WC_CYC - 1)) begin
                    ctl_d.ph  = PH_SCAN;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            PH_SCAN: begin
                if (ctl_q.cnt == CNT_W'(PAGE_BYTES - 1)) begin
                    ctl_d.ph  = PH_IDLE;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctl_d.ph  = PH_IDLE;
                ctl_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_PWR, cnt: '0, have: 1'b0, pg: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = (ctl_q.ph == PH_PWR) || (ctl_q.ph == PH_PROG) || (ctl_q.ph == PH_SCAN);
    assign cm_en   = (ctl_q.ph == PH_SCAN) && buf_rvld;
    assign cm_addr = {ctl_q.pg, ctl_q.cnt[OFF_W-1:0]};
    assign cm_data = buf_rdata;

    // R2
    load_after_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.ph == PH_LOAD) |-> $past(unl_done));

    // R4
    miss_to_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unl_miss |=> (busy && !cm_en));

    // R8
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en |-> busy);

    // R9
    busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!buf_we && !unl_done));

    // R7
    gap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_LOAD && !wr_en && ctl_q.cnt == CNT_W'(BLC_CYC - 1)) |=> busy);

endmodule

// File: tb/locked_page_loader_test.sv
module locked_page_loader_test;

    localparam int CLK_PERIOD = 10;
    localparam int PON = 50;
    localparam int BLC = 20;
    localparam int WC  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy, cm_en;
    logic [16:0] cm_addr;
    logic [7:0]  cm_data;

    int checks = 0;
    int errors = 0;
    int commits = 0;
    bit finished = 1'b0;
    logic [7:0] shadow [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    locked_page_loader uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .cm_en(cm_en),
        .cm_addr(cm_addr), .cm_data(cm_data)
    );

    // Behavioural reference: 0 power-up, 1 locked, 2 loading, 3 programming, 4 scan
    int  m_ph = 0, m_cnt = 0, m_step = 0, m_pg = 0;
    bit  m_have = 0;
    bit  m_ld [128];
    int  m_val [128];

    function automatic bit unl_ok(int step, logic [16:0] a, logic [7:0] d);
        case (step)
            0: return a[14:0] == 15'h5555 && d == 8'hAA;
            1: return a[14:0] == 15'h2AAA && d == 8'h55;
            default: return a[14:0] == 15'h5555 && d == 8'hA0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_step = 0; m_have = 0;
            foreach (m_ld[i]) m_ld[i] = 0;
        end else begin
            case (m_ph)
                0: if (m_cnt == PON - 1) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
                1: if (wr_en) begin
                    if (unl_ok(m_step, wr_addr, wr_data)) begin
                        if (m_step == 2) begin
                            m_step = 0; m_ph = 2; m_cnt = 0; m_have = 0;
                            foreach (m_ld[i]) m_ld[i] = 0;
                        end else m_step++;
                    end else begin
                        m_step = 0; m_ph = 3; m_cnt = 0;
                        foreach (m_ld[i]) m_ld[i] = 0;
                    end
                end
                2: if (wr_en && (!m_have || int'(wr_addr[16:7]) == m_pg)) begin
                    m_have = 1; m_pg = int'(wr_addr[16:7]); m_cnt = 0;
                    m_ld[wr_addr[6:0]] = 1; m_val[wr_addr[6:0]] = int'(wr_data);
                end else if (m_cnt == BLC - 1) begin m_ph = 3; m_cnt = 0; end
                else m_cnt++;
                3: if (m_cnt == WC - 1) begin m_ph = 4; m_cnt = 0; end else m_cnt++;
                default: if (m_cnt == 127) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        bit eb, ee;
        eb = (m_ph == 0 || m_ph == 3 || m_ph == 4);
        ee = (m_ph == 4) && m_ld[m_cnt];
        checks++;
        if (busy !== eb) begin
            errors++;
            $display("FAIL R7/R8 busy per-cycle: actual %0b expected %0b (t=%0t)", busy, eb, $time);
        end
        checks++;
        if (cm_en !== ee) begin
            errors++;
            $display("FAIL R8 cm_en per-cycle: actual %0b expected %0b (t=%0t)", cm_en, ee, $time);
        end else if (ee) begin
            checks++;
            if (cm_addr !== 17'((m_pg << 7) | m_cnt) || cm_data !== 8'(m_val[m_cnt])) begin
                errors++;
                $display("FAIL R6 commit: actual %h/%h expected %h/%h", cm_addr, cm_data,
                         17'((m_pg << 7) | m_cnt), 8'(m_val[m_cnt]));
            end
        end
        if (rst_n && cm_en === 1'b1) begin
            shadow[int'(cm_addr)] = cm_data;
            commits++;
        end
    end

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock(input logic [16:0] hi);
        wr(hi | 17'h05555, 8'hAA);
        wr(hi | 17'h02AAA, 8'h55);
        wr(hi | 17'h05555, 8'hA0);
    endtask

    task automatic wait_locked();
        do @(negedge clk); while (m_ph != 1);
    endtask

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_mem(input string tag, input int a, input int exp);
        int act;
        act = shadow.exists(a) ? int'(shadow[a]) : -1;
        chk(tag, act == exp, act, exp);
    endtask

    task automatic chk_absent(input string tag, input int a);
        chk(tag, !shadow.exists(a), shadow.exists(a) ? int'(shadow[a]) : -1, -1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: busy high right after reset, writes ignored during power-up
        chk("R1 busy after reset", busy === 1'b1, busy, 1);
        repeat (5) @(negedge clk);
        unlock(17'h0);
        wr(17'h00480, 8'h5A);
        wait_locked();
        chk("R1 busy low after power-up", busy === 1'b0, busy, 0);
        chk_absent("R1 power-up write ignored", 17'h00480);

        // R5/R6: page 5, out-of-order, overwrite, both ends of the page
        unlock(17'h0);
        wr((5 << 7) | 10, 8'h11);
        wr((5 << 7) | 3,  8'h22);
        wr((5 << 7) | 10, 8'h33);
        wr((5 << 7) | 127, 8'h44);
        wr((5 << 7) | 0,  8'h55);
        wait_locked();
        chk_mem("R6 overwrite keeps last", (5 << 7) | 10, 8'h33);
        chk_mem("R6 out of order", (5 << 7) | 3, 8'h22);
        chk_mem("R5 top offset", (5 << 7) | 127, 8'h44);
        chk_mem("R5 offset zero", (5 << 7) | 0, 8'h55);
        chk_absent("R6 unloaded byte untouched", (5 << 7) | 4);
        chk_absent("R3 unlock data not stored 5555", 17'h05555);
        chk_absent("R3 unlock data not stored 2AAA", 17'h02AAA);
        chk("R6 commit count", commits == 4, commits, 4);

        // R2: upper address bits are don't-care in the unlock compare
        wr(17'h15555, 8'hAA);
        wr(17'h12AAA, 8'h55);
        wr(17'h05555, 8'hA0);
        wr((7 << 7) | 2, 8'h66);
        wait_locked();
        chk_mem("R2 unlock on low 15 bits", (7 << 7) | 2, 8'h66);

        // R8: locked again after the program; plain write is not stored
        base = commits;
        wr((9 << 7) | 1, 8'h99);
        @(negedge clk);
        chk("R4 plain write starts busy", busy === 1'b1, busy, 1);
        // R9: a full unlock and load while busy is ignored
        unlock(17'h0);
        wr((8 << 7) | 0, 8'h88);
        wait_locked();
        chk_absent("R8 locked after program", (9 << 7) | 1);
        chk_absent("R9 write while busy ignored", (8 << 7) | 0);

        // R4: broken second step
        wr(17'h05555, 8'hAA);
        wr(17'h02AAB, 8'h55);
        @(negedge clk);
        chk("R4 miss starts busy", busy === 1'b1, busy, 1);
        wait_locked();
        chk("R4 no commit after miss", commits == base, commits, base);

        // R5: other-page load discarded, gap timer not restarted
        unlock(17'h0);
        wr((10 << 7) | 5, 8'hA5);
        repeat (11) @(negedge clk);
        wr((11 << 7) | 5, 8'hB5);
        repeat (11) @(negedge clk);
        wr((10 << 7) | 6, 8'hA6);
        wait_locked();
        chk_mem("R5 latched page kept", (10 << 7) | 5, 8'hA5);
        chk_absent("R5 other page discarded", (11 << 7) | 5);
        chk_absent("R5 timer not restarted", (10 << 7) | 6);

        // R7: gap of exactly BLC accepted, BLC+1 rejected
        unlock(17'h0);
        wr((12 << 7) | 0, 8'hC0);
        repeat (BLC - 1) @(negedge clk);
        wr((12 << 7) | 1, 8'hC1);
        repeat (BLC) @(negedge clk);
        wr((12 << 7) | 2, 8'hC2);
        wait_locked();
        chk_mem("R7 byte at limit accepted", (12 << 7) | 1, 8'hC1);
        chk_absent("R7 byte past limit rejected", (12 << 7) | 2);

        // R7/R8: unlock with no data commits nothing
        base = commits;
        unlock(17'h0);
        wait_locked();
        chk("R8 empty load commits nothing", commits == base, commits, base);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule